// File: doc/BRIEF.md
# Transient Event Capture Monitor

This block watches a group of signals that are expected to hold a steady level while a test runs. Each channel has a programmable reference level. Two sticky flags record transients on each channel. One flag catches any edge that moves the signal away from its reference. The other catches any edge that brings it back. A one-cycle glitch therefore sets both flags of its channel.

A flag is not reported at once. It must stay set for a run of consecutive clocks first, so that a brief upset of the flag storage is not counted as an event. A free-running window timer fires once per period. When it fires, all confirmed flags are copied into snapshot registers and those flags are cleared. Flags that are set but not yet confirmed carry over to the next window, as does any edge that arrives in the clear cycle itself.

Software reads the results through a small parallel register port. The port gives the snapshots, a per-pair coincidence summary and a saturating count of confirmed flags.

Top module: `tevt_monitor`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every readable register (addresses 0 to 4) reads zero.
- R2: Address 0 holds the NCH-bit reference level, one bit per channel, in bits [NCH-1:0]; it is written with reg_wr_en and read back zero-extended. Upper data bits are dropped, and writes to addresses 1, 2 and 4 change nothing.
- R3: An edge that moves a channel away from its reference sets that channel's departure flag. With reference 0 this is a rising edge; with reference 1 it is a falling edge. An edge back toward the reference sets the return flag.
- R4: Flags are sticky: a transient lasting a single clock stays recorded until the window end that reports it.
- R5: A flag is reported only after it has been set for FILT_LEN consecutive clocks. A flag set too late in a window is left out of that snapshot and is reported in the following one.
- R6: Every PERIOD clocks, the first time at the PERIOD-th rising edge after reset release, the confirmed flags are loaded into the snapshot registers and cleared. Departure flags go to address 1 and return flags to address 2, with bit i meaning channel i. Between loads the snapshots hold.
- R7: An edge detected in the clock where the window ends is kept and reported in the next window, even when the same flag is being cleared in that clock.
- R8: Address 3 holds a CNT_W-bit count. At each window end it grows by the number of confirmed flags of both kinds, and it saturates at all-ones instead of wrapping.
- R9: Any write to address 3 clears the count; a window end in the same clock still adds its confirmed flags to the cleared value.
- R10: Address 4 bit i is loaded at each window end with 1 when channels 2i and 2i+1 both had a confirmed flag of the same kind in that window.
- R11: Changing the reference level while the monitored signals are steady records no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_i | input | NCH | Monitored signals, already synchronous to clk |
| reg_wr_en | input | 1 | Register write strobe, one write per clock |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |

## Verification
The bench builds the block with four channels, a 16-clock window, a three-clock filter and a 6-bit count. The short window lets every test step be placed at an exact phase inside a window. That covers the last clock that still confirms a flag, the first clock that misses it, and the clear clock itself. The narrow count reaches saturation after eight windows of full-channel glitches. Two pairs are enough to show both a coincident pair and a pair whose flags differ in kind.

// File: rtl/tevt_pkg.sv
// Package: shared register address map for the transient event monitor.
// Assumes a 3-bit register address space; unused addresses read zero.
package tevt_pkg;

    localparam int ADDR_W = 3;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADDR_REF      = 3'd0;
    localparam reg_addr_t ADDR_SNAP_DEP = 3'd1;
    localparam reg_addr_t ADDR_SNAP_RET = 3'd2;
    localparam reg_addr_t ADDR_COUNT    = 3'd3;
    localparam reg_addr_t ADDR_PAIR     = 3'd4;

endpackage

// File: rtl/tevt_sticky_flag.sv
// Module: one sticky transient flag followed by a persistence filter.
// The flag sets on evt_i and is reported (conf_o) only after it has been
// set for FILT_LEN consecutive clocks. win_end_i clears only a confirmed
// flag; an unconfirmed one keeps counting, and a new event in the clear
// clock re-arms the flag. Assumes FILT_LEN >= 1.
module tevt_sticky_flag #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic win_end_i,
    output logic flag_o,
    output logic conf_o
);

    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic          flag_q;
    logic [CW-1:0] run_q;
    logic          drop;

    assign conf_o  = flag_q && (run_q == FULL);
    assign flag_o  = flag_q;
    assign drop    = win_end_i && conf_o;

    // Sticky flag: set by an event, released only once reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= evt_i || (flag_q && !drop);
        end
    end

    // Persistence counter: counts clocks the flag has stayed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (drop || !flag_q) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/tevt_chan_capture.sv
// Module: per-channel edge detector with departure and return flags.
// Judges each edge against the channel's reference level: an edge away
// from it is a departure, an edge toward it a return. Assumes mon_i is
// already synchronous to clk. The previous sample resets to 0.
module tevt_chan_capture #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_i,
    input  logic ref_i,
    input  logic win_end_i,
    output logic dep_flag_o,
    output logic ret_flag_o,
    output logic dep_conf_o,
    output logic ret_conf_o
);

    logic prev_q;
    logic rise, fall;
    logic dep_evt, ret_evt;

    // Previous sample of the monitored signal for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= mon_i;
        end
    end

    // Map raw edges onto departure/return using the reference level.
    always_comb begin
        rise    = mon_i && !prev_q;
        fall    = !mon_i && prev_q;
        dep_evt = ref_i ? fall : rise;
        ret_evt = ref_i ? rise : fall;
    end

    tevt_sticky_flag #(.FILT_LEN(FILT_LEN)) u_dep (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (dep_evt),
        .win_end_i (win_end_i),
        .flag_o    (dep_flag_o),
        .conf_o    (dep_conf_o)
    );

    tevt_sticky_flag #(.FILT_LEN(FILT_LEN)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (ret_evt),
        .win_end_i (win_end_i),
        .flag_o    (ret_flag_o),
        .conf_o    (ret_conf_o)
    );

endmodule

// File: rtl/tevt_window_timer.sv
// Module: free-running window timer.
// Raises win_end_o for one clock every PERIOD clocks; the first pulse is
// in the clock before the PERIOD-th edge after reset. Assumes PERIOD >= 2.
module tevt_window_timer #(
    parameter int PERIOD = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end_o
);

    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] tmr_q;

    assign win_end_o = (tmr_q == LAST);

    // Cycle counter wrapping at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (win_end_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tevt_reg_bank.sv
// Module: reference register, snapshot registers, pair summary and the
// saturating event count, with a combinational read mux.
// Assumes NCH is even, NCH <= DATA_W and CNT_W <= DATA_W.
module tevt_reg_bank
    import tevt_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  reg_addr_t         addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              win_end_i,
    input  logic [NCH-1:0]    dep_conf_i,
    input  logic [NCH-1:0]    ret_conf_i,
    output logic [NCH-1:0]    ref_o,
    output logic [NCH-1:0]    snap_dep_o,
    output logic [NCH-1:0]    snap_ret_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int NPAIR = NCH / 2;
    localparam int AW    = $clog2(2 * NCH + 1);
    localparam int SUM_W = ((CNT_W > AW) ? CNT_W : AW) + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [NCH-1:0]   ref_q, snap_dep_q, snap_ret_q;
    logic [NPAIR-1:0] pair_q, pair_now;
    logic [CNT_W-1:0] count_q;
    logic [AW-1:0]    add;
    logic [SUM_W-1:0] sum;
    logic             cnt_clr;

    assign cnt_clr = wr_en_i && (addr_i == ADDR_COUNT);

    generate
        if (DATA_W > NCH) begin : g_spare
            logic spare_unused;
            assign spare_unused = ^wdata_i[DATA_W-1:NCH];
        end
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            assign pair_now[p] = (dep_conf_i[2*p] && dep_conf_i[2*p+1]) ||
                                 (ret_conf_i[2*p] && ret_conf_i[2*p+1]);
        end
    endgenerate

    // Reference level register, written at its own address only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (wr_en_i && (addr_i == ADDR_REF)) begin
            ref_q <= wdata_i[NCH-1:0];
        end
    end

    // Snapshot of confirmed flags and pair coincidence at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_dep_q <= '0;
            snap_ret_q <= '0;
            pair_q     <= '0;
        end else if (win_end_i) begin
            snap_dep_q <= dep_conf_i;
            snap_ret_q <= ret_conf_i;
            pair_q     <= pair_now;
        end
    end

    // Number of confirmed flags of both kinds in this window.
    always_comb begin
        add = '0;
        for (int i = 0; i < NCH; i++) begin
            add = add + AW'(dep_conf_i[i]) + AW'(ret_conf_i[i]);
        end
        sum = (cnt_clr ? '0 : SUM_W'(count_q)) + (win_end_i ? SUM_W'(add) : '0);
    end

    // Saturating event count; a write clears it before the add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (sum > CNT_MAX) begin
            count_q <= CNT_MAX[CNT_W-1:0];
        end else begin
            count_q <= sum[CNT_W-1:0];
        end
    end

    // Read mux, zero-extending each field.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_REF:      rdata_o[NCH-1:0]   = ref_q;
            ADDR_SNAP_DEP: rdata_o[NCH-1:0]   = snap_dep_q;
            ADDR_SNAP_RET: rdata_o[NCH-1:0]   = snap_ret_q;
            ADDR_COUNT:    rdata_o[CNT_W-1:0] = count_q;
            ADDR_PAIR:     rdata_o[NPAIR-1:0] = pair_q;
            default:       rdata_o = '0;
        endcase
    end

    assign ref_o      = ref_q;
    assign snap_dep_o = snap_dep_q;
    assign snap_ret_o = snap_ret_q;
    assign count_o    = count_q;

endmodule

// File: rtl/tevt_monitor.sv
// Module: top of the transient event capture monitor.
// One capture channel per monitored signal, a window timer and a register
// bank. Assumes mon_i is synchronous to clk, NCH even, NCH <= DATA_W and
// CNT_W <= DATA_W. Default PERIOD is 5 ms at a 100 MHz clock.
module tevt_monitor
    import tevt_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int FILT_LEN = 3,
    parameter int PERIOD   = 500000,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    mon_i,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    logic             win_tick;
    logic [NCH-1:0]   ref_level;
    logic [NCH-1:0]   cap_dep, cap_ret, conf_dep, conf_ret;
    logic [NCH-1:0]   snap_dep, snap_ret;
    logic [CNT_W-1:0] count_val;

    tevt_window_timer #(.PERIOD(PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_o (win_tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            tevt_chan_capture #(.FILT_LEN(FILT_LEN)) u_cap (
                .clk        (clk),
                .rst_n      (rst_n),
                .mon_i      (mon_i[c]),
                .ref_i      (ref_level[c]),
                .win_end_i  (win_tick),
                .dep_flag_o (cap_dep[c]),
                .ret_flag_o (cap_ret[c]),
                .dep_conf_o (conf_dep[c]),
                .ret_conf_o (conf_ret[c])
            );
        end
    endgenerate

    tevt_reg_bank #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .win_end_i  (win_tick),
        .dep_conf_i (conf_dep),
        .ret_conf_i (conf_ret),
        .ref_o      (ref_level),
        .snap_dep_o (snap_dep),
        .snap_ret_o (snap_ret),
        .count_o    (count_val),
        .rdata_o    (reg_rdata)
    );

endmodule

// File: rtl/tevt_monitor_chk.sv
// Module: assertion checker bound to tevt_monitor.
// Observes register port writes, the window tick, the sticky flags, the
// snapshots and the count.
module tevt_monitor_chk
    import tevt_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              win_tick,
    input logic [NCH-1:0]    ref_level,
    input logic [NCH-1:0]    cap_dep,
    input logic [NCH-1:0]    cap_ret,
    input logic [NCH-1:0]    snap_dep,
    input logic [NCH-1:0]    snap_ret,
    input logic [CNT_W-1:0]  count_val
);

    logic cnt_clr;
    assign cnt_clr = reg_wr_en && (reg_addr == ADDR_COUNT);

    p_ref_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_REF) |=> ref_level == $past(reg_wdata[NCH-1:0]));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> ((cap_dep & $past(cap_dep)) == $past(cap_dep)) &&
                      ((cap_ret & $past(cap_ret)) == $past(cap_ret)));

    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> $stable(snap_dep) && $stable(snap_ret));

    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |=> !win_tick);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> count_val >= $past(count_val));

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val == {CNT_W{1'b1}} && !cnt_clr) |=> count_val == {CNT_W{1'b1}});

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !win_tick) |=> count_val == '0);

endmodule

bind tevt_monitor tevt_monitor_chk #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .win_tick  (win_tick),
    .ref_level (ref_level),
    .cap_dep   (cap_dep),
    .cap_ret   (cap_ret),
    .snap_dep  (snap_dep),
    .snap_ret  (snap_ret),
    .count_val (count_val)
);

// File: tb/tevt_monitor_bench.sv
// Bench: vector table of reference/level steps, then directed corner tests.
module tevt_monitor_bench;

    localparam int NCH = 4, FILT_LEN = 3, PERIOD = 16, CNT_W = 6, DATA_W = 16;
    localparam int NVEC = 8;
    localparam int CMAX = (1 << CNT_W) - 1;
    // {ref, mon, expected departure, expected return, expected pair}
    localparam logic [17:0] VEC [NVEC] = '{
        {4'b0000, 4'b0101, 4'b0101, 4'b0000, 2'b00},
        {4'b0000, 4'b0011, 4'b0010, 4'b0100, 2'b00},
        {4'b1111, 4'b0011, 4'b0000, 4'b0000, 2'b00},   // R11: reference change only
        {4'b1111, 4'b1111, 4'b0000, 4'b1100, 2'b10},
        {4'b1111, 4'b0000, 4'b1111, 4'b0000, 2'b11},
        {4'b0110, 4'b0110, 4'b0000, 4'b0110, 2'b00},
        {4'b0110, 4'b1001, 4'b1111, 4'b0000, 2'b11},
        {4'b0000, 4'b0000, 4'b0000, 4'b1001, 2'b00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    mon = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    int                cyc = 0;
    int                nchk = 0;
    int                nerr = 0;
    int                exp_cnt = 0;
    logic [DATA_W-1:0] rv;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tevt_monitor #(.NCH(NCH), .FILT_LEN(FILT_LEN), .PERIOD(PERIOD),
                   .CNT_W(CNT_W), .DATA_W(DATA_W)) u_tevt_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_i     (mon),
        .reg_wr_en (wr_en),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (cyc % PERIOD != 0);
    endtask

    task automatic wait_phase(input int ph);
        while (cyc % PERIOD != ph) @(negedge clk);
    endtask

    task automatic check_snap(input string tag, input logic [3:0] d, input logic [3:0] r,
                              input logic [1:0] p);
        rd(3'd1, rv); check({tag, " departure"}, rv, d);
        rd(3'd2, rv); check({tag, " return"}, rv, r);
        rd(3'd4, rv); check({tag, " pair"}, rv, p);
    endtask

    task automatic add_cnt(input int n);
        exp_cnt = (exp_cnt + n > CMAX) ? CMAX : exp_cnt + n;
    endtask

    task automatic check_reset(input string tag);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), rv);
            check(tag, rv, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 20000);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset("R1 reset value");

        // Table walk: R3, R6, R10, R11 and the count R8
        wait_tick();
        for (int k = 0; k < NVEC; k++) begin
            wr(3'd0, DATA_W'(VEC[k][17:14]));
            mon = VEC[k][13:10];
            wait_tick();
            check_snap($sformatf("R3 R6 R10 vector %0d", k), VEC[k][9:6], VEC[k][5:2], VEC[k][1:0]);
            add_cnt($countones(VEC[k][9:2]));
        end
        rd(3'd3, rv); check("R8 count after table", rv, exp_cnt);

        // R4: single-clock glitch sets both flags
        mon = 4'b0001; @(negedge clk); mon = 4'b0000;
        wait_tick();
        check_snap("R4 one-clock glitch", 4'b0001, 4'b0001, 2'b00);
        add_cnt(2);

        // R5: last phase that confirms versus one that misses the window
        wait_phase(PERIOD - 5); mon = 4'b0100;
        wait_phase(PERIOD - 2); mon = 4'b0110;
        wait_tick();
        check_snap("R5 late flag withheld", 4'b0100, 4'b0000, 2'b00);
        add_cnt(1);
        wait_tick();
        check_snap("R5 late flag reported next", 4'b0010, 4'b0000, 2'b00);
        add_cnt(1);

        // R7: event in the clear clock on a flag being cleared
        mon = 4'b0111;
        wait_phase(PERIOD - 2); mon = 4'b0110;
        wait_phase(PERIOD - 1); mon = 4'b0111;
        wait_tick();
        check_snap("R7 clear-clock window", 4'b0001, 4'b0000, 2'b00);
        add_cnt(1);
        wait_tick();
        check_snap("R7 kept event", 4'b0001, 4'b0001, 2'b00);
        add_cnt(2);
        mon = 4'b0000;
        wait_tick();
        check_snap("R10 return pair", 4'b0000, 4'b0111, 2'b01);
        add_cnt(3);

        // R2: read-only addresses ignore writes; reference truncation
        wr(3'd1, 16'hFFFF); wr(3'd2, 16'hFFFF); wr(3'd4, 16'hFFFF);
        check_snap("R2 writes ignored", 4'b0000, 4'b0111, 2'b01);
        wr(3'd0, 16'hFFF5);
        rd(3'd0, rv); check("R2 reference readback", rv, 16'h0005);
        wr(3'd0, 16'h0000);
        wait_tick();
        check_snap("R11 reference change only", 4'b0000, 4'b0000, 2'b00);
        rd(3'd3, rv); check("R8 accumulated count", rv, exp_cnt);

        // R9: clear, then clear coinciding with a window end
        wr(3'd3, 16'h0000);
        rd(3'd3, rv); check("R9 clear", rv, 0);
        mon = 4'b1000; @(negedge clk); mon = 4'b0000;
        wait_phase(PERIOD - 1);
        wr(3'd3, 16'h0000);
        rd(3'd3, rv); check("R9 clear with window end", rv, 2);
        exp_cnt = 2;

        // R8: saturation
        for (int w = 0; w < 9; w++) begin
            mon = 4'b1111; @(negedge clk); mon = 4'b0000;
            wait_tick();
            add_cnt(8);
            if (w >= 6) begin
                rd(3'd3, rv);
                check($sformatf("R8 saturation window %0d", w), rv, exp_cnt);
            end
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset("R1 reset after run");

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule